// File: doc/BRIEF.md
# Chainable 16-Bit Serial Command Slave

This block is the serial front end of a small register-controlled peripheral. An external master lowers a chip-select, clocks 16-bit command words into a data input, and raises chip-select to execute them. Each word holds a direction flag, a seven-bit register address and an eight-bit data byte. A write turns into a one-cycle write strobe towards a register bank. A read turns into a one-cycle read strobe. The returned byte overwrites the low half of the shift register, so the master collects it in the second byte of its next frame.

The serial output repeats the input stream 15.5 serial clocks later and changes on falling serial-clock edges. Several devices can therefore be chained, each output feeding the next device's input, with clock and chip-select shared. The serial clock, chip-select and data input are brought into the system clock domain through synchronizer stages and edge detectors. All state runs on the system clock, and the serial clock must be several times slower than it.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, `miso` is 0, neither strobe is asserted, and the shift register holds zero, so the first frame returns 0x0000 on `miso`.
- R2: While `cs_n` is low, each rising `sclk` edge shifts `mosi` in MSB first. When `cs_n` rises on a word with bit 15 = 0 and a nonzero address in bits 14:8, `reg_wr` pulses for exactly one cycle, with `reg_addr` = bits 14:8 and `reg_wdata` = bits 7:0.
- R3: When `cs_n` rises on a word with bit 15 = 1 and a nonzero address, `reg_rd` pulses for exactly one cycle with that address, and `reg_wr` stays low.
- R4: In the `reg_rd` cycle, `reg_rdata` replaces shift bits 7:0. The dummy data bits sent with the read are lost. The next frame returns the read word's bits 15:8 followed by the register byte.
- R5: Address 0 is a no-op. No strobe is issued for either direction, and the shift contents are left unchanged for the next frame.
- R6: `miso` changes only after a falling `sclk` edge seen while `cs_n` is low. Over a 16-clock frame it presents the word held before the frame, MSB first, so each bit appears 15.5 clocks after it entered.
- R7: When more than 16 bits are clocked in during one `cs_n` low period, only the last 16 are decoded.
- R8: Toggling `sclk` and `mosi` while `cs_n` is high changes neither the shift register nor the strobes.
- R9: `reg_wr` and `reg_rd` are never asserted together, and a strobe never carries address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip-select |
| mosi | input | 1 | Serial command input |
| miso | output | 1 | Serial output, delayed input stream or read data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_addr | output | 7 | Register address for either strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the `reg_rd` cycle |

## Verification
A table of frames alternates writes, reads of the same addresses with all-ones and zero dummy bytes, and no-op words in both directions. Each frame's `miso` stream is compared with the word the previous frame left behind. This separates a correct one-frame delay from a same-frame return, a wrong byte order, and dummy data leaking into read results. Directed frames follow. A 24-bit frame shows whether the first or the last 16 bits are decoded. Clock and data toggles with chip-select high show whether idle bus traffic leaks into the shift register. A check that `miso` holds across every rising edge tells falling-edge output apart from rising-edge output.

// File: rtl/spi_chain_slave.sv
module spi_chain_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = WORD_W - 1 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic [SYNC_STAGES:0]   sclk_p, cs_p;
  logic [SYNC_STAGES-1:0] din_p;
  logic [WORD_W-1:0]      shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-1:0], cs_n};
      din_p  <= {din_p[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sclk_s, cs_s, din_s, sclk_rise, sclk_fall, cs_rise;
  assign sclk_s    = sclk_p[SYNC_STAGES-1];
  assign cs_s      = cs_p[SYNC_STAGES-1];
  assign din_s     = din_p[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_p[SYNC_STAGES];
  assign sclk_fall = ~sclk_s & sclk_p[SYNC_STAGES];
  assign cs_rise   = cs_s & ~cs_p[SYNC_STAGES];

  logic              cmd_read, cmd_live;
  logic [ADDR_W-1:0] cmd_addr;
  assign cmd_read = shift_q[WORD_W-1];
  assign cmd_addr = shift_q[WORD_W-2:DATA_W];
  assign cmd_live = cs_rise && (cmd_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (sclk_rise && !cs_s) begin
      shift_q <= {shift_q[WORD_W-2:0], din_s};
    end else if (reg_rd) begin
      shift_q[DATA_W-1:0] <= reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso <= 1'b0;
    end else if (sclk_fall && !cs_s) begin
      miso <= shift_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= cmd_live & ~cmd_read;
      reg_rd <= cmd_live & cmd_read;
      if (cs_rise) begin
        reg_addr  <= cmd_addr;
        reg_wdata <= shift_q[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miso,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              fall_evt,
  input logic              cs_hi,
  input logic [WORD_W-1:0] shift_q
);

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R9
  AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr || reg_rd) |-> (reg_addr != '0)); // R5
  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(miso) |-> $past(fall_evt)); // R6
  AST_IDLE_HOLDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && $past(cs_hi) && !$past(reg_rd)) |-> $stable(shift_q)); // R8

endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .miso     (miso),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .fall_evt (sclk_fall),
  .cs_hi    (cs_s),
  .shift_q  (shift_q)
);

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];

  int errors = 0, checks = 0, wr_cnt = 0, rd_cnt = 0, edge_errs = 0;
  logic [6:0] last_wa, last_ra;
  logic [7:0] last_wd;
  bit done = 0;

  always #5 clk = ~clk;

  spi_chain_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    if (reg_wr) begin wr_cnt <= wr_cnt + 1; last_wa <= reg_addr; last_wd <= reg_wdata; end
    if (reg_rd) begin rd_cnt <= rd_cnt + 1; last_ra <= reg_addr; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, output logic [15:0] got);
    logic m0;
    got = '0;
    cs_n = 1'b0;
    tick(6);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      tick(8);
      m0 = miso;
      got = {got[14:0], miso};
      sclk = 1'b1;
      tick(8);
      if (miso !== m0) edge_errs++;
      sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1;
    tick(12);
  endtask

  // {expected strobe: 0 none, 1 write, 2 read, word}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 16'h0A5C}, {2'd1, 16'h1233}, {2'd2, 16'h8AFF}, {2'd2, 16'h9200},
    {2'd0, 16'h0077}, {2'd0, 16'h803C}, {2'd1, 16'h7F01}, {2'd2, 16'hFFAA},
    {2'd0, 16'h0000}
  };

  initial begin
    logic [15:0] got, exp_prev;
    logic [7:0]  model [128];
    int w0, r0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk("R1 miso after reset", {31'd0, miso}, 32'd0);
    chk("R1 no strobe after reset", {30'd0, reg_wr, reg_rd}, 32'd0);
    exp_prev = 16'h0000;

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      logic [6:0]  a;
      w = VEC[v][15:0];
      a = w[14:8];
      w0 = wr_cnt; r0 = rd_cnt;
      xfer({16'd0, w}, 16, got);
      chk("R6 R4 frame returns previous word", {16'd0, got}, {16'd0, exp_prev});
      case (VEC[v][17:16])
        2'd1: begin
          chk("R2 one write strobe", wr_cnt - w0, 1);
          chk("R2 write addr/data", {17'd0, last_wa, last_wd}, {17'd0, a, w[7:0]});
          chk("R3 no read on write", rd_cnt - r0, 0);
          model[a] = w[7:0];
          exp_prev = w;
        end
        2'd2: begin
          chk("R3 one read strobe", rd_cnt - r0, 1);
          chk("R3 read addr", {25'd0, last_ra}, {25'd0, a});
          chk("R3 no write on read", wr_cnt - w0, 0);
          exp_prev = {w[15:8], model[a]};
        end
        default: begin
          chk("R5 no-op issues no strobe", (wr_cnt - w0) + (rd_cnt - r0), 0);
          exp_prev = w;
        end
      endcase
    end

    // R7: 24-bit frame, first byte would decode as a read of 0x7F
    w0 = wr_cnt; r0 = rd_cnt;
    xfer(32'h00FF0B66, 24, got);
    chk("R7 last 16 bits written", wr_cnt - w0, 1);
    chk("R7 no read from leading bits", rd_cnt - r0, 0);
    chk("R7 decoded addr/data", {17'd0, last_wa, last_wd}, {17'd0, 7'h0B, 8'h66});

    // R8: bus traffic with chip-select high
    w0 = wr_cnt; r0 = rd_cnt;
    for (int k = 0; k < 12; k++) begin
      mosi = k[0] ^ k[2];
      tick(8); sclk = 1'b1; tick(8); sclk = 1'b0;
    end
    chk("R8 no strobe while deselected", (wr_cnt - w0) + (rd_cnt - r0), 0);
    xfer(32'h0, 16, got);
    chk("R8 shift unchanged while deselected", {16'd0, got}, 32'h0B66);
    chk("R6 miso steady across rising edges", edge_errs, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule